// File: doc/BRIEF.md
# Floating-Point Register Producer Table

This block keeps track of which in-flight operation will next produce each of eight floating-point registers. The eight even-numbered architectural registers F0 to F14 map onto entries 0 to 7, where entry i stands for register F(2i). Each entry holds the register's architectural value. It also holds either a producer tag or a busy-clear state. A busy-clear entry means the stored value is current.

An issue stage drives up to two source register numbers and gets back, for each source, one of two answers: the current value, or the tag the operation must wait on. On an issue strobe, the destination entry records the new producer tag. This happens even when an older producer is still outstanding, which resolves write-after-write ordering.

The result bus carries a tag and a value. Every entry whose recorded producer equals that tag takes the value and becomes busy-clear. An entry whose producer was superseded ignores the broadcast. The operand-holding stations are outside this block.

Top module: `fp_producer_table`

## Requirements
- R1: After reset every entry is busy-clear and every register value is zero.
- R2: An issue with destination d and tag t makes a lookup of d, from the next cycle on, report pending with tag t.
- R3: An issue to a destination that already has a pending producer replaces the old tag with the new one.
- R4: A broadcast whose tag equals an entry's recorded tag writes the value into that register and clears its pending state at the same clock edge.
- R5: A broadcast whose tag differs from an entry's recorded tag leaves that entry's value and tag unchanged. This covers the result of a superseded producer.
- R6: A lookup of a busy-clear entry reports not pending and returns the register value.
- R7: When an issue to register d and a broadcast matching d's current tag fall in the same cycle, d afterwards reports pending with the new issue's tag.
- R8: A lookup of an entry whose tag equals a broadcast in the same cycle returns the broadcast value and reports not pending.
- R9: Source lookups in an issue cycle see the state before that issue, so a source equal to the destination does not see the new tag.
- R10: A broadcast updates every entry that holds its tag, not only one.
- R11: Register numbers are 3 bits: value i selects F(2i). The tag output is meaningful only while pending is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue strobe; records the destination producer |
| iss_dst | input | 3 | Destination register number |
| iss_tag | input | TAG_W | Tag of the issuing operation |
| iss_src_a | input | 3 | First source register number |
| iss_src_b | input | 3 | Second source register number |
| src_a_pending | output | 1 | First source still waits on a producer |
| src_a_tag | output | TAG_W | Producer tag for the first source |
| src_a_value | output | DATA_W | Current value of the first source |
| src_b_pending | output | 1 | Second source still waits on a producer |
| src_b_tag | output | TAG_W | Producer tag for the second source |
| src_b_value | output | DATA_W | Current value of the second source |
| cdb_valid | input | 1 | Result broadcast strobe |
| cdb_tag | input | TAG_W | Tag of the broadcasting producer |
| cdb_value | input | DATA_W | Broadcast result value |

## Verification
The bench broadcasts the tag of a producer that has been overridden. A design that skipped the tag compare would let the stale result overwrite the register. It checks an issue and a matching broadcast to the same register in one cycle; a design with the wrong priority would drop the new producer and lose the dependency. It checks a lookup during a matching broadcast, where a design without the bypass would hand out a tag that is never broadcast again and leave the station waiting forever. It also checks two registers sharing one tag, and a source equal to the destination of the same issue.

// File: rtl/fp_producer_pkg.sv
package fp_producer_pkg;
    localparam int DEF_REGS   = 8;
    localparam int DEF_TAG_W  = 4;
    localparam int DEF_DATA_W = 32;
endpackage

// File: rtl/fp_producer_entry.sv
module fp_producer_entry #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_hit,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              busy_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o
);
    typedef struct packed {
        logic              busy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t st_d, st_q;
    logic   wb_match;

    always_comb begin
        st_d     = st_q;
        wb_match = cdb_valid && st_q.busy && (st_q.tag == cdb_tag);
        if (wb_match) begin
            st_d.value = cdb_value;
            st_d.busy  = 1'b0;
        end
        if (iss_hit) begin
            st_d.busy = 1'b1;
            st_d.tag  = iss_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign tag_o   = st_q.tag;
    assign value_o = st_q.value;

    // R2
    issue_records_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_hit |=> (busy_o && tag_o == $past(iss_tag)));

    // R4
    writeback_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && busy_o && tag_o == cdb_tag && !iss_hit)
        |=> (!busy_o && value_o == $past(cdb_value)));

    // R5
    stale_result_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && busy_o && tag_o != cdb_tag)
        |=> (value_o == $past(value_o)));
endmodule

// File: rtl/fp_producer_lookup.sv
module fp_producer_lookup #(
    parameter int REGS   = 8,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(REGS)
) (
    input  logic [SEL_W-1:0]             sel,
    input  logic [REGS-1:0]              busy,
    input  logic [REGS-1:0][TAG_W-1:0]   tags,
    input  logic [REGS-1:0][DATA_W-1:0]  values,
    input  logic                         cdb_valid,
    input  logic [TAG_W-1:0]             cdb_tag,
    input  logic [DATA_W-1:0]            cdb_value,
    output logic                         pending,
    output logic [TAG_W-1:0]             tag,
    output logic [DATA_W-1:0]            value
);
    logic bypass;

    always_comb begin
        tag     = tags[sel];
        bypass  = busy[sel] && cdb_valid && (cdb_tag == tags[sel]);
        pending = busy[sel] && !bypass;
        value   = bypass ? cdb_value : values[sel];
    end
endmodule

// File: rtl/fp_producer_table.sv
module fp_producer_table
    import fp_producer_pkg::*;
#(
    parameter int REGS   = DEF_REGS,
    parameter int TAG_W  = DEF_TAG_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int SEL_W = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [SEL_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [SEL_W-1:0]  iss_src_a,
    input  logic [SEL_W-1:0]  iss_src_b,
    output logic              src_a_pending,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_a_value,
    output logic              src_b_pending,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic [DATA_W-1:0] src_b_value,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value
);
    logic [REGS-1:0]             busy;
    logic [REGS-1:0][TAG_W-1:0]  tags;
    logic [REGS-1:0][DATA_W-1:0] values;

    for (genvar g = 0; g < REGS; g++) begin : g_entry
        fp_producer_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_hit   (iss_valid && (iss_dst == SEL_W'(g))),
            .iss_tag   (iss_tag),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .busy_o    (busy[g]),
            .tag_o     (tags[g]),
            .value_o   (values[g])
        );
    end

    fp_producer_lookup #(.REGS(REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_a (
        .sel(iss_src_a), .busy(busy), .tags(tags), .values(values),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .pending(src_a_pending), .tag(src_a_tag), .value(src_a_value)
    );

    fp_producer_lookup #(.REGS(REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_b (
        .sel(iss_src_b), .busy(busy), .tags(tags), .values(values),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .pending(src_b_pending), .tag(src_b_tag), .value(src_b_value)
    );

    // R8
    no_stale_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_pending |-> !(cdb_valid && cdb_tag == src_a_tag));

    // R7
    issue_wins_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && cdb_valid && iss_src_a == iss_dst && src_a_value == cdb_value
         && !src_a_pending && busy[iss_dst])
        |=> (busy[$past(iss_dst)] && tags[$past(iss_dst)] == $past(iss_tag)));
endmodule

// File: tb/fp_producer_table_test.sv
module fp_producer_table_test;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 4;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic        iv;
        logic [2:0]  dst;
        logic [3:0]  tag;
        logic        cv;
        logic [3:0]  ctag;
        logic [31:0] cval;
        logic [2:0]  a;
        logic [2:0]  b;
        logic        ap;
        logic [31:0] aexp;
        logic        bp;
        logic [31:0] bexp;
    } vec_t;

    // aexp/bexp: tag when pending, value otherwise
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd0,3'd1, 1'b0,32'h0,  1'b0,32'h0},  // R1 reset state
        '{1'b1,3'd3,4'd1, 1'b0,4'd0,32'h0,  3'd3,3'd3, 1'b0,32'h0,  1'b0,32'h0},  // R9 old mapping
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd3,3'd0, 1'b1,32'd1,  1'b0,32'h0},  // R2 tag recorded
        '{1'b1,3'd1,4'd2, 1'b1,4'd1,32'h11, 3'd3,3'd1, 1'b0,32'h11, 1'b0,32'h0},  // R8 bypass
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd3,3'd1, 1'b0,32'h11, 1'b1,32'd2},  // R4 R6
        '{1'b1,3'd1,4'd3, 1'b0,4'd0,32'h0,  3'd1,3'd0, 1'b1,32'd2,  1'b0,32'h0},  // R3 override
        '{1'b0,3'd0,4'd0, 1'b1,4'd2,32'h22, 3'd1,3'd3, 1'b1,32'd3,  1'b0,32'h11}, // R5 stale
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd1,3'd0, 1'b1,32'd3,  1'b0,32'h0},  // R5 after
        '{1'b1,3'd1,4'd4, 1'b1,4'd3,32'h33, 3'd1,3'd3, 1'b0,32'h33, 1'b0,32'h11}, // R7 collision
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd1,3'd3, 1'b1,32'd4,  1'b0,32'h11}, // R7 new tag wins
        '{1'b1,3'd0,4'd6, 1'b0,4'd0,32'h0,  3'd0,3'd0, 1'b0,32'h0,  1'b0,32'h0},  // R10 setup
        '{1'b1,3'd7,4'd6, 1'b0,4'd0,32'h0,  3'd0,3'd7, 1'b1,32'd6,  1'b0,32'h0},  // R10 setup
        '{1'b0,3'd0,4'd0, 1'b1,4'd6,32'h66, 3'd0,3'd7, 1'b0,32'h66, 1'b0,32'h66}, // R10 R8
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd0,3'd7, 1'b0,32'h66, 1'b0,32'h66}, // R10 both written
        '{1'b0,3'd0,4'd0, 1'b1,4'd4,32'h44, 3'd1,3'd2, 1'b0,32'h44, 1'b0,32'h0},  // R8 R11
        '{1'b0,3'd0,4'd0, 1'b0,4'd0,32'h0,  3'd1,3'd3, 1'b0,32'h44, 1'b0,32'h11}  // R4 R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [2:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic [TAG_W-1:0] iss_tag = '0, cdb_tag = '0;
    logic cdb_valid = 1'b0;
    logic [DATA_W-1:0] cdb_value = '0;
    logic src_a_pending, src_b_pending;
    logic [TAG_W-1:0] src_a_tag, src_b_tag;
    logic [DATA_W-1:0] src_a_value, src_b_value;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_producer_table uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .src_a_pending(src_a_pending), .src_a_tag(src_a_tag), .src_a_value(src_a_value),
        .src_b_pending(src_b_pending), .src_b_tag(src_b_tag), .src_b_value(src_b_value),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
    );

    task automatic check_port(input string req, input logic pend, input logic [TAG_W-1:0] tg,
                              input logic [DATA_W-1:0] val, input logic exp_p,
                              input logic [31:0] exp_v);
        logic [31:0] got;
        got = pend ? 32'(tg) : val;
        checks++;
        if (pend !== exp_p || got !== exp_v) begin
            errors++;
            $display("FAIL %s: pending=%0b data=%h expected pending=%0b data=%h",
                     req, pend, got, exp_p, exp_v);
        end
    endtask

    task automatic drive_idle();
        iss_valid = 1'b0; cdb_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            iss_valid = VEC[i].iv;  iss_dst = VEC[i].dst;  iss_tag = VEC[i].tag;
            cdb_valid = VEC[i].cv;  cdb_tag = VEC[i].ctag; cdb_value = VEC[i].cval;
            iss_src_a = VEC[i].a;   iss_src_b = VEC[i].b;
            @(negedge clk);
            check_port($sformatf("vector %0d src a", i), src_a_pending, src_a_tag,
                       src_a_value, VEC[i].ap, VEC[i].aexp);
            check_port($sformatf("vector %0d src b", i), src_b_pending, src_b_tag,
                       src_b_value, VEC[i].bp, VEC[i].bexp);
            @(posedge clk); #1;
        end

        // R1: reset mid-run clears pending producers and register values
        drive_idle();
        iss_valid = 1'b1; iss_dst = 3'd2; iss_tag = 4'd9;
        @(posedge clk); #1;
        drive_idle();
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        iss_src_a = 3'd2; iss_src_b = 3'd3;
        @(negedge clk);
        check_port("R1 reset clears tag", src_a_pending, src_a_tag, src_a_value, 1'b0, 32'h0);
        check_port("R1 reset clears value", src_b_pending, src_b_tag, src_b_value, 1'b0, 32'h0);

        // R5: broadcast with no matching entry changes nothing
        @(posedge clk); #1;
        cdb_valid = 1'b1; cdb_tag = 4'd9; cdb_value = 32'hDEAD;
        @(posedge clk); #1;
        drive_idle();
        @(negedge clk);
        check_port("R5 unmatched broadcast", src_a_pending, src_a_tag, src_a_value, 1'b0, 32'h0);

        // R3 R4: override then only the newest producer writes
        @(posedge clk); #1;
        iss_valid = 1'b1; iss_dst = 3'd5; iss_tag = 4'd10;
        @(posedge clk); #1;
        iss_tag = 4'd11;
        @(posedge clk); #1;
        drive_idle();
        cdb_valid = 1'b1; cdb_tag = 4'd10; cdb_value = 32'hBAD0;
        @(posedge clk); #1;
        cdb_tag = 4'd11; cdb_value = 32'hC0DE;
        @(posedge clk); #1;
        drive_idle();
        iss_src_a = 3'd5;
        @(negedge clk);
        check_port("R3 R4 newest producer value", src_a_pending, src_a_tag, src_a_value,
                   1'b0, 32'hC0DE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule